// File: doc/BRIEF.md
# Indirect Control Register Bank

This block holds the control and context registers that a drawing processor's command stream reaches by register number instead of by bus address. A command port presents a 16-bit command word carrying a 9-bit register number and a direction bit. A load command then consumes one or two 16-bit words from a write word stream. A dump command emits one or two 16-bit words on a read word stream. Registers of up to 16 bits travel as one word. Address-sized registers travel as two words, the low half first. The block packs every value into the word image, zero-fills the unused bits, and rejects bad accesses with an error pulse.

The register numbers are sparse. One orientation register keeps its two fields in separate bytes of the word. The pixel-depth register is written through one number and read back through another. A few register values are also driven out to the neighbouring engines. The stack pointer can step downward on request from the engine that pushes onto the stack.

Top module: `irb_unit`

## Requirements
- R1: After reset every register is zero, except the version register, which reads 5. `busy_o`, `err_o` and `rd_valid_o` are low.
- R2: A command is accepted at a clock edge where `cmd_valid_i` is high and `busy_o` is low. Bits 8:0 of `cmd_word_i` select the register and bits 15:9 must be zero. `cmd_load_i` = 1 requests a load and 0 requests a dump.
- R3: Narrow registers move as one right-justified word. On a load, bits above the register width are dropped. On a dump, those bits read as zero. The narrow registers are:
  - 0x003 poll mask, 6 bits, driven on `poll_mask_o`;
  - 0x004 interrupt mask, 8 bits, driven on `irq_mask_o`;
  - 0x013 spacing, 16 bits;
  - 0x014 character count, 16 bits;
  - 0x016 bitmap width in words, 16 bits;
  - 0x019 scratch, 16 bits;
  - 0x090 clip X maximum, 16 bits;
  - 0x091 clip Y maximum, 16 bits;
  - 0x094 clip X minimum, 16 bits;
  - 0x095 clip Y minimum, 16 bits.
- R4: The font base (0x10B), the stack pointer (0x10C) and the instruction pointer (0x1AC) are ADDR_W bits wide and move as two words. The first word is bits 15:0. The second word carries the upper bits in its bits ADDR_W-17:0, and its other bits are dropped on a load and read as zero on a dump.
- R5: A two-word load changes its register only at the edge that accepts the second word. After the first word the old value is still visible.
- R6: The orientation register (0x007) keeps word bits 1:0 and 9:8. Every other bit reads back as zero.
- R7: Pixel depth (BPP_W bits, driven on `bpp_o`) is loaded through 0x008 and dumped through 0x09F. 0x008 cannot be dumped and 0x09F cannot be loaded.
- R8: The version register (0x017) is read-only and dumps VERSION.
- R9: These commands are rejected: an unknown number, nonzero bits 15:9, a load to a dump-only number, and a dump from a load-only number. A rejected command raises `err_o` for exactly the one cycle after it is accepted. It changes no register, consumes and produces no words, and leaves the block idle.
- R10: On a dump, `rd_valid_o` is high in the cycles right after acceptance, one cycle per word, low word first. The words show the register value as it was at the accepting edge.
- R11: On an accepted legal command, `busy_o` rises at the accepting edge. It falls after the last word has moved. Commands presented while `busy_o` is high are ignored.
- R12: `sp_dec_i` lowers the stack pointer by SP_STEP, modulo 2^ADDR_W, at each edge where the same edge does not load the stack pointer. Its value is driven on `sp_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_load_i | input | 1 | 1 = load, 0 = dump |
| cmd_word_i | input | 16 | Command word with the register number in bits 8:0 |
| wr_valid_i | input | 1 | Load data word present |
| wr_data_i | input | 16 | Load data word |
| sp_dec_i | input | 1 | Step the stack pointer downward |
| busy_o | output | 1 | Transfer in progress |
| err_o | output | 1 | Rejected command pulse |
| rd_valid_o | output | 1 | Dump word present |
| rd_data_o | output | 16 | Dump word |
| poll_mask_o | output | 6 | Poll mask value |
| irq_mask_o | output | 8 | Interrupt mask value |
| bpp_o | output | BPP_W | Pixel depth value |
| sp_o | output | ADDR_W | Stack pointer value |

## Verification
The bench builds the block with its defaults: ADDR_W = 22, BPP_W = 4, SP_STEP = 2 and VERSION = 5. With a 22-bit width, the second word of a wide load has ten bits that must be dropped, so the high-word masking can be observed directly. The same width makes the stack pointer's wrap from zero to 0x3FFFFE reachable with a single step. Because VERSION is 5, a load attempted on the read-only register shows up as a change from a known nonzero value.

// File: rtl/irb_pkg.sv
package irb_pkg;
  localparam int ID_W   = 9;
  localparam int WORD_W = 16;
  localparam int POLL_W = 6;
  localparam int IRQ_W  = 8;

  typedef enum logic [3:0] {
    RS_POLL, RS_IRQ, RS_ORIENT, RS_BPP, RS_FONT, RS_SP, RS_SPACE, RS_CCNT,
    RS_WSPAN, RS_VER, RS_TEMP, RS_XMAX, RS_YMAX, RS_XMIN, RS_YMIN, RS_IP
  } reg_sel_e;

  typedef enum logic [2:0] {ST_IDLE, ST_LD_LO, ST_LD_HI, ST_DP_LO, ST_DP_HI} xfer_st_e;

  typedef struct packed {
    logic     hit;
    logic     can_rd;
    logic     can_wr;
    logic     wide;
    reg_sel_e sel;
  } id_info_t;

  function automatic id_info_t lookup_id(input logic [ID_W-1:0] id);
    id_info_t r;
    r.hit    = 1'b1;
    r.can_rd = 1'b1;
    r.can_wr = 1'b1;
    r.wide   = 1'b0;
    r.sel    = RS_TEMP;
    case (id)
      9'h003: r.sel = RS_POLL;
      9'h004: r.sel = RS_IRQ;
      9'h007: r.sel = RS_ORIENT;
      9'h008: begin r.sel = RS_BPP; r.can_rd = 1'b0; end
      9'h09F: begin r.sel = RS_BPP; r.can_wr = 1'b0; end
      9'h013: r.sel = RS_SPACE;
      9'h014: r.sel = RS_CCNT;
      9'h016: r.sel = RS_WSPAN;
      9'h017: begin r.sel = RS_VER; r.can_wr = 1'b0; end
      9'h019: r.sel = RS_TEMP;
      9'h090: r.sel = RS_XMAX;
      9'h091: r.sel = RS_YMAX;
      9'h094: r.sel = RS_XMIN;
      9'h095: r.sel = RS_YMIN;
      9'h10B: begin r.sel = RS_FONT; r.wide = 1'b1; end
      9'h10C: begin r.sel = RS_SP;   r.wide = 1'b1; end
      9'h1AC: begin r.sel = RS_IP;   r.wide = 1'b1; end
      default: r.hit = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/irb_id_decode.sv
module irb_id_decode
  import irb_pkg::*;
(
  input  logic [WORD_W-1:0] cmd_word_i,
  input  logic              cmd_load_i,
  output logic              legal_o,
  output logic              wide_o,
  output reg_sel_e          sel_o
);
  id_info_t info;
  logic     pad_zero;

  always_comb begin
    info     = lookup_id(cmd_word_i[ID_W-1:0]);
    pad_zero = (cmd_word_i[WORD_W-1:ID_W] == '0);
    legal_o  = pad_zero && info.hit && (cmd_load_i ? info.can_wr : info.can_rd);
    wide_o   = info.wide;
    sel_o    = info.sel;
  end
endmodule

// File: rtl/irb_reg_file.sv
module irb_reg_file
  import irb_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int BPP_W   = 4,
  parameter int SP_STEP = 2,
  parameter int VERSION = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  reg_sel_e          wr_sel_i,
  input  logic [ADDR_W-1:0] wr_img_i,
  input  logic              sp_dec_i,
  input  reg_sel_e          rd_sel_i,
  output logic [ADDR_W-1:0] rd_img_o,
  output logic [POLL_W-1:0] poll_o,
  output logic [IRQ_W-1:0]  irq_o,
  output logic [BPP_W-1:0]  bpp_o,
  output logic [ADDR_W-1:0] sp_o
);
  localparam int N_W16 = 8;
  localparam reg_sel_e W16_SEL [N_W16] = '{RS_SPACE, RS_CCNT, RS_WSPAN, RS_TEMP,
                                          RS_XMAX, RS_YMAX, RS_XMIN, RS_YMIN};
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(SP_STEP);

  logic [POLL_W-1:0] poll_q;
  logic [IRQ_W-1:0]  irq_q;
  logic [3:0]        orient_q;
  logic [BPP_W-1:0]  bpp_q;
  logic [ADDR_W-1:0] font_q, sp_q, ip_q;
  logic [WORD_W-1:0] w16_q [N_W16];

  function automatic logic hit(input reg_sel_e s);
    return wr_en_i && (wr_sel_i == s);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      poll_q   <= '0;
      irq_q    <= '0;
      orient_q <= '0;
      bpp_q    <= '0;
      font_q   <= '0;
      sp_q     <= '0;
      ip_q     <= '0;
    end else begin
      if (hit(RS_POLL))   poll_q   <= wr_img_i[POLL_W-1:0];
      if (hit(RS_IRQ))    irq_q    <= wr_img_i[IRQ_W-1:0];
      if (hit(RS_ORIENT)) orient_q <= {wr_img_i[9:8], wr_img_i[1:0]};
      if (hit(RS_BPP))    bpp_q    <= wr_img_i[BPP_W-1:0];
      if (hit(RS_FONT))   font_q   <= wr_img_i;
      if (hit(RS_IP))     ip_q     <= wr_img_i;
      if (hit(RS_SP))     sp_q     <= wr_img_i;
      else if (sp_dec_i)  sp_q     <= sp_q - STEP;
    end
  end

  for (genvar g = 0; g < N_W16; g++) begin : g_w16
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              w16_q[g] <= '0;
      else if (hit(W16_SEL[g])) w16_q[g] <= wr_img_i[WORD_W-1:0];
    end
  end

  always_comb begin
    rd_img_o = '0;
    case (rd_sel_i)
      RS_POLL:   rd_img_o = ADDR_W'(poll_q);
      RS_IRQ:    rd_img_o = ADDR_W'(irq_q);
      RS_ORIENT: begin
        rd_img_o[9:8] = orient_q[3:2];
        rd_img_o[1:0] = orient_q[1:0];
      end
      RS_BPP:    rd_img_o = ADDR_W'(bpp_q);
      RS_VER:    rd_img_o = ADDR_W'(16'(VERSION));
      RS_FONT:   rd_img_o = font_q;
      RS_SP:     rd_img_o = sp_q;
      RS_IP:     rd_img_o = ip_q;
      default: begin
        for (int k = 0; k < N_W16; k++)
          if (rd_sel_i == W16_SEL[k]) rd_img_o = ADDR_W'(w16_q[k]);
      end
    endcase
  end

  assign poll_o = poll_q;
  assign irq_o  = irq_q;
  assign bpp_o  = bpp_q;
  assign sp_o   = sp_q;
endmodule

// File: rtl/irb_xfer_ctl.sv
module irb_xfer_ctl
  import irb_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_load_i,
  input  logic              legal_i,
  input  logic              wide_i,
  input  reg_sel_e          sel_i,
  input  logic              wr_valid_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_img_i,
  output logic              busy_o,
  output logic              err_o,
  output logic              rd_valid_o,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              wr_en_o,
  output reg_sel_e          wr_sel_o,
  output logic [ADDR_W-1:0] wr_img_o
);
  localparam int HI_W = ADDR_W - WORD_W;

  xfer_st_e          state_q;
  reg_sel_e          sel_q;
  logic              wide_q, err_q;
  logic [WORD_W-1:0] lo_q;
  logic [ADDR_W-1:0] snap_q;
  logic              accept;

  assign accept = cmd_valid_i && (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= RS_POLL;
      wide_q  <= 1'b0;
      err_q   <= 1'b0;
      lo_q    <= '0;
      snap_q  <= '0;
    end else begin
      err_q <= accept && !legal_i;
      case (state_q)
        ST_IDLE: if (accept && legal_i) begin
          sel_q   <= sel_i;
          wide_q  <= wide_i;
          snap_q  <= rd_img_i;  // dump image frozen at acceptance
          state_q <= cmd_load_i ? ST_LD_LO : ST_DP_LO;
        end
        ST_LD_LO: if (wr_valid_i) begin
          lo_q    <= wr_data_i;
          state_q <= wide_q ? ST_LD_HI : ST_IDLE;
        end
        ST_LD_HI: if (wr_valid_i) state_q <= ST_IDLE;
        ST_DP_LO: state_q <= wide_q ? ST_DP_HI : ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    wr_en_o  = wr_valid_i && ((state_q == ST_LD_LO && !wide_q) || state_q == ST_LD_HI);
    wr_img_o = (state_q == ST_LD_HI) ? {wr_data_i[HI_W-1:0], lo_q} : ADDR_W'(wr_data_i);
    case (state_q)
      ST_DP_LO: rd_data_o = snap_q[WORD_W-1:0];
      ST_DP_HI: rd_data_o = WORD_W'(snap_q[ADDR_W-1:WORD_W]);
      default:  rd_data_o = '0;
    endcase
  end

  assign wr_sel_o   = sel_q;
  assign rd_valid_o = (state_q == ST_DP_LO) || (state_q == ST_DP_HI);
  assign busy_o     = (state_q != ST_IDLE);
  assign err_o      = err_q;
endmodule

// File: rtl/irb_unit.sv
module irb_unit
  import irb_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int BPP_W   = 4,
  parameter int SP_STEP = 2,
  parameter int VERSION = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_load_i,
  input  logic [15:0]       cmd_word_i,
  input  logic              wr_valid_i,
  input  logic [15:0]       wr_data_i,
  input  logic              sp_dec_i,
  output logic              busy_o,
  output logic              err_o,
  output logic              rd_valid_o,
  output logic [15:0]       rd_data_o,
  output logic [5:0]        poll_mask_o,
  output logic [7:0]        irq_mask_o,
  output logic [BPP_W-1:0]  bpp_o,
  output logic [ADDR_W-1:0] sp_o
);
  logic              legal, wide, wr_en;
  reg_sel_e          cmd_sel, wr_sel;
  logic [ADDR_W-1:0] rd_img, wr_img;

  irb_id_decode u_dec (
    .cmd_word_i (cmd_word_i),
    .cmd_load_i (cmd_load_i),
    .legal_o    (legal),
    .wide_o     (wide),
    .sel_o      (cmd_sel)
  );

  irb_xfer_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_load_i  (cmd_load_i),
    .legal_i     (legal),
    .wide_i      (wide),
    .sel_i       (cmd_sel),
    .wr_valid_i  (wr_valid_i),
    .wr_data_i   (wr_data_i),
    .rd_img_i    (rd_img),
    .busy_o      (busy_o),
    .err_o       (err_o),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o),
    .wr_en_o     (wr_en),
    .wr_sel_o    (wr_sel),
    .wr_img_o    (wr_img)
  );

  irb_reg_file #(
    .ADDR_W(ADDR_W), .BPP_W(BPP_W), .SP_STEP(SP_STEP), .VERSION(VERSION)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_sel_i (wr_sel),
    .wr_img_i (wr_img),
    .sp_dec_i (sp_dec_i),
    .rd_sel_i (cmd_sel),
    .rd_img_o (rd_img),
    .poll_o   (poll_mask_o),
    .irq_o    (irq_mask_o),
    .bpp_o    (bpp_o),
    .sp_o     (sp_o)
  );
endmodule

// File: rtl/irb_unit_chk.sv
module irb_unit_chk #(
  parameter int ADDR_W  = 22,
  parameter int BPP_W   = 4,
  parameter int SP_STEP = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic              sp_dec_i,
  input logic              busy_o,
  input logic              err_o,
  input logic              rd_valid_o,
  input logic [5:0]        poll_mask_o,
  input logic [7:0]        irq_mask_o,
  input logic [BPP_W-1:0]  bpp_o,
  input logic [ADDR_W-1:0] sp_o
);
  AST_ERR_AFTER_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(cmd_valid_i)); // R9
  AST_ERR_STAYS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!busy_o && !rd_valid_o)); // R9
  AST_ERR_NO_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($stable(poll_mask_o) && $stable(irq_mask_o) && $stable(bpp_o))); // R9
  AST_RD_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> busy_o); // R11
  AST_SP_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sp_dec_i && !busy_o) |=> (sp_o == $past(sp_o) - ADDR_W'(SP_STEP))); // R12
endmodule

bind irb_unit irb_unit_chk #(.ADDR_W(ADDR_W), .BPP_W(BPP_W), .SP_STEP(SP_STEP)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .sp_dec_i    (sp_dec_i),
  .busy_o      (busy_o),
  .err_o       (err_o),
  .rd_valid_o  (rd_valid_o),
  .poll_mask_o (poll_mask_o),
  .irq_mask_o  (irq_mask_o),
  .bpp_o       (bpp_o),
  .sp_o        (sp_o)
);

// File: tb/irb_unit_tb_top.sv
module irb_unit_tb_top;
  localparam int ADDR_W = 22;
  localparam int BPP_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_load = 1'b0, wr_valid = 1'b0, sp_dec = 1'b0;
  logic [15:0] cmd_word = '0, wr_data = '0;
  logic busy, err, rd_valid;
  logic [15:0] rd_data;
  logic [5:0] poll_mask;
  logic [7:0] irq_mask;
  logic [BPP_W-1:0] bpp;
  logic [ADDR_W-1:0] sp;

  int checks = 0, failures = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];
  logic [15:0] e_w;
  string e_t;

  always #10 clk = ~clk;

  irb_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_load_i(cmd_load),
    .cmd_word_i(cmd_word), .wr_valid_i(wr_valid), .wr_data_i(wr_data), .sp_dec_i(sp_dec),
    .busy_o(busy), .err_o(err), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .poll_mask_o(poll_mask), .irq_mask_o(irq_mask), .bpp_o(bpp), .sp_o(sp)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected dump words
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R10 unexpected dump word act=%h exp=none", rd_data);
      end else begin
        e_w = exp_q.pop_front();
        e_t = tag_q.pop_front();
        chk(rd_data == e_w, e_t, 32'(rd_data), 32'(e_w));
      end
    end
  end

  task automatic send_cmd(input logic [15:0] w, input bit ld);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_word = w; cmd_load = ld;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic send_word(input logic [15:0] w);
    wr_valid = 1'b1; wr_data = w;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic load1(input logic [15:0] id, input logic [15:0] w);
    send_cmd(id, 1'b1);
    send_word(w);
  endtask

  task automatic load2(input logic [15:0] id, input logic [15:0] lo, input logic [15:0] hi);
    send_cmd(id, 1'b1);
    send_word(lo);
    send_word(hi);
  endtask

  task automatic dump(input logic [15:0] id, input int n, input logic [15:0] e0,
                      input logic [15:0] e1, input string tag);
    exp_q.push_back(e0); tag_q.push_back(tag);
    if (n == 2) begin exp_q.push_back(e1); tag_q.push_back(tag); end
    send_cmd(id, 1'b0);
    repeat (2) @(negedge clk);
  endtask

  task automatic bad_cmd(input logic [15:0] id, input bit ld, input string tag);
    send_cmd(id, ld);
    chk(err == 1'b1 && busy == 1'b0, tag, {30'b0, err, busy}, 32'h2);
    @(negedge clk);
    chk(err == 1'b0, {tag, " pulse width"}, 32'(err), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && err == 0 && rd_valid == 0, "R1 flags", {29'b0, busy, err, rd_valid}, 0);
    chk(sp == 0 && bpp == 0 && poll_mask == 0 && irq_mask == 0, "R1 outputs", 32'(sp), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    dump(16'h003, 1, 16'h0000, 0, "R1 poll reset");
    dump(16'h017, 1, 16'h0005, 0, "R1 R8 version");
    dump(16'h10C, 2, 16'h0000, 16'h0000, "R1 sp reset");

    // R2 R3 narrow registers
    load1(16'h003, 16'hFFFF);
    chk(poll_mask == 6'h3F, "R3 poll_mask_o", 32'(poll_mask), 32'h3F);
    dump(16'h003, 1, 16'h003F, 0, "R3 poll masked");
    load1(16'h004, 16'hA5C3);
    chk(irq_mask == 8'hC3, "R3 irq_mask_o", 32'(irq_mask), 32'hC3);
    dump(16'h004, 1, 16'h00C3, 0, "R3 irq masked");
    load1(16'h014, 16'h1234);
    load1(16'h090, 16'hBEEF);
    load1(16'h091, 16'h0F0F);
    load1(16'h095, 16'h8001);
    dump(16'h014, 1, 16'h1234, 0, "R3 char count");
    dump(16'h090, 1, 16'hBEEF, 0, "R3 xmax");
    dump(16'h091, 1, 16'h0F0F, 0, "R3 ymax");
    dump(16'h095, 1, 16'h8001, 0, "R3 ymin");
    dump(16'h094, 1, 16'h0000, 0, "R3 xmin untouched");

    // R4 R5 wide register, atomic update
    send_cmd(16'h10C, 1'b1);
    send_word(16'hBEEF);
    chk(sp == '0, "R5 sp after first word", 32'(sp), 0);
    chk(busy == 1'b1, "R11 busy mid load", 32'(busy), 1);
    send_word(16'hFFEA);
    chk(sp == 22'h2ABEEF, "R4 R5 sp after second word", 32'(sp), 32'h2ABEEF);
    dump(16'h10C, 2, 16'hBEEF, 16'h002A, "R4 sp dump");
    load2(16'h1AC, 16'h0102, 16'h8413);
    dump(16'h1AC, 2, 16'h0102, 16'h0013, "R4 ip dump");

    // R6 orientation packing
    load1(16'h007, 16'hFFFF);
    dump(16'h007, 1, 16'h0303, 0, "R6 orient all ones");
    load1(16'h007, 16'h0201);
    dump(16'h007, 1, 16'h0201, 0, "R6 orient fields");

    // R7 pixel depth split ids
    load1(16'h008, 16'hFFF7);
    chk(bpp == 4'h7, "R7 bpp_o", 32'(bpp), 7);
    dump(16'h09F, 1, 16'h0007, 0, "R7 bpp readback");
    bad_cmd(16'h008, 1'b0, "R7 R9 dump of load-only id");
    bad_cmd(16'h09F, 1'b1, "R7 R9 load of dump-only id");

    // R8 R9 errors
    bad_cmd(16'h017, 1'b1, "R8 R9 load of version");
    dump(16'h017, 1, 16'h0005, 0, "R8 version unchanged");
    bad_cmd(16'h055, 1'b1, "R9 unknown id");
    bad_cmd(16'h0203, 1'b1, "R2 R9 nonzero upper bits");
    dump(16'h003, 1, 16'h003F, 0, "R9 poll unchanged");

    // R11 commands ignored while busy
    send_cmd(16'h003, 1'b1);
    cmd_valid = 1'b1; cmd_word = 16'h017; cmd_load = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1 && err == 1'b0, "R11 ignored cmd", {30'b0, busy, err}, 32'h2);
    send_word(16'h0015);
    dump(16'h003, 1, 16'h0015, 0, "R11 load completed");

    // R12 stack step and wrap, R10 snapshot
    sp_dec = 1'b1; @(negedge clk); sp_dec = 1'b0;
    chk(sp == 22'h2ABEED, "R12 sp step", 32'(sp), 32'h2ABEED);
    exp_q.push_back(16'hBEED); tag_q.push_back("R10 snapshot lo");
    exp_q.push_back(16'h002A); tag_q.push_back("R10 snapshot hi");
    @(negedge clk);
    cmd_valid = 1'b1; cmd_word = 16'h10C; cmd_load = 1'b0; sp_dec = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; sp_dec = 1'b0;
    repeat (2) @(negedge clk);
    chk(sp == 22'h2ABEEB, "R12 sp step during dump", 32'(sp), 32'h2ABEEB);
    load2(16'h10C, 16'h0000, 16'h0000);
    sp_dec = 1'b1; @(negedge clk); sp_dec = 1'b0;
    chk(sp == 22'h3FFFFE, "R12 sp wrap", 32'(sp), 32'h3FFFFE);
    dump(16'h10C, 2, 16'hFFFE, 16'h003F, "R12 sp wrap dump");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all dump words seen", 32'(exp_q.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule